// File: doc/BRIEF.md
# SECDED Codeword Checker and Corrector

This block inspects a 39-bit protected word and returns the 32-bit payload it carries, repaired when possible. The word holds six Hamming check bits at the power-of-two positions, payload bits in the remaining low positions, and one overall-parity bit at the top. The block has no clock and no storage. It recomputes the six-bit syndrome and the overall parity, flips one bit when a single upset is found, and reports a double upset that it cannot repair.

A two-bit status reports the outcome. A separate flag is set when the single upset hit a protection bit rather than payload, so that scrubbing logic can tell a harmless repair from a repaired payload. The shared package also provides an encoder function that builds valid words in the same layout.

Top module: `secded_check`

## Requirements
- R1: Positions are numbered 1 to 39, and position p is bit p-1 of `cw_i`. Check bit k sits at position 2^k for k = 0..5. Payload bit 0 sits at position 3, and the remaining payload bits fill the other non-power-of-two positions up to 38 in ascending order. Position 39 holds even parity over the whole word. For a valid word, `data_o` equals the payload, `status_o` is 2'b00 and `meta_fix_o` is 0.
- R2: If exactly one payload bit is flipped, `data_o` equals the original payload, `status_o` is 2'b01 and `meta_fix_o` is 0.
- R3: If exactly one check bit (position 1, 2, 4, 8, 16 or 32) is flipped, `data_o` equals the original payload, `status_o` is 2'b01 and `meta_fix_o` is 1.
- R4: If only the overall-parity bit at position 39 is flipped, `data_o` equals the original payload, `status_o` is 2'b01 and `meta_fix_o` is 1.
- R5: If exactly two bits are flipped, `status_o` is 2'b10, `meta_fix_o` is 0, and `data_o` is the payload read from the received word with no correction.
- R6: A nonzero syndrome that names no position (above 38) with odd overall parity gives `status_o` 2'b10 and uncorrected `data_o`.
- R7: `status_o` never takes the value 2'b11, and `meta_fix_o` is only 1 when `status_o` is 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cw_i | input | 39 | Received codeword, bit p-1 holding position p |
| data_o | output | 32 | Extracted payload, corrected where possible |
| status_o | output | 2 | 00 clean, 01 single corrected, 10 double detected |
| meta_fix_o | output | 1 | Single upset fell on a check bit or the parity bit |

## Verification
Several payload patterns (all zeros, all ones, alternating, sparse) are encoded by an independent model in the bench. Each is applied clean, with every payload bit flipped in turn, with every check bit flipped, and with the parity bit flipped. These cases separate payload repair from protection-bit repair. Pairs of flips that span payload, check and parity bits show that double upsets are flagged and left untouched. A crafted triple flip whose syndrome lands above position 38 exercises the out-of-range path.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 32;
  localparam int CHK_W  = 6;
  localparam int CW_W   = DATA_W + CHK_W + 1;

  localparam logic [1:0] ST_OK  = 2'b00;
  localparam logic [1:0] ST_FIX = 2'b01;
  localparam logic [1:0] ST_DBL = 2'b10;

  function automatic bit is_pow2(int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // 1-based codeword position of payload bit idx
  function automatic int pos_of_data(int idx);
    int cnt;
    cnt = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == idx) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  // positions 1..CW_W-1 covered by check bit k
  function automatic logic [CW_W-1:0] cover_mask(int k);
    logic [CW_W-1:0] m;
    m = '0;
    for (int p = 1; p < CW_W; p++) m[p-1] = ((p >> k) & 1) == 1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] extract(logic [CW_W-1:0] cw);
    logic [DATA_W-1:0] d;
    for (int i = 0; i < DATA_W; i++) d[i] = cw[pos_of_data(i)-1];
    return d;
  endfunction

  function automatic logic [CW_W-1:0] encode(logic [DATA_W-1:0] d);
    logic [CW_W-1:0] cw;
    cw = '0;
    for (int i = 0; i < DATA_W; i++) cw[pos_of_data(i)-1] = d[i];
    for (int k = 0; k < CHK_W; k++) cw[(1 << k) - 1] = ^(cw & cover_mask(k));
    cw[CW_W-1] = ^cw[CW_W-2:0];
    return cw;
  endfunction
endpackage

// File: rtl/secded_syndrome.sv
module secded_syndrome
  import secded_pkg::*;
#(
  parameter int CHK_N = CHK_W,
  parameter int CW_N  = CW_W
) (
  input  logic [CW_N-1:0]  cw_i,
  output logic [CHK_N-1:0] syn_o,
  output logic             odd_o
);
  for (genvar k = 0; k < CHK_N; k++) begin : g_syn
    localparam logic [CW_N-1:0] MASK = cover_mask(k);
    assign syn_o[k] = ^(cw_i & MASK);
  end
  assign odd_o = ^cw_i;
endmodule

// File: rtl/secded_classify.sv
module secded_classify
  import secded_pkg::*;
#(
  parameter int CHK_N = CHK_W,
  parameter int CW_N  = CW_W
) (
  input  logic [CHK_N-1:0] syn_i,
  input  logic             odd_i,
  output logic             flip_en_o,
  output logic [1:0]       status_o,
  output logic             meta_o
);
  logic syn_nz;
  logic in_range;

  assign syn_nz   = |syn_i;
  assign in_range = int'(syn_i) <= CW_N - 1;

  always_comb begin
    flip_en_o = 1'b0;
    meta_o    = 1'b0;
    status_o  = ST_OK;
    if (!syn_nz && odd_i) begin
      status_o = ST_FIX;
      meta_o   = 1'b1;
    end else if (syn_nz && odd_i && in_range) begin
      status_o  = ST_FIX;
      flip_en_o = 1'b1;
      meta_o    = is_pow2(int'(syn_i));
    end else if (syn_nz) begin
      status_o = ST_DBL;
    end
  end
endmodule

// File: rtl/secded_flip.sv
module secded_flip
  import secded_pkg::*;
#(
  parameter int CHK_N = CHK_W,
  parameter int CW_N  = CW_W
) (
  input  logic [CW_N-1:0]  cw_i,
  input  logic [CHK_N-1:0] syn_i,
  input  logic             en_i,
  output logic [CW_N-1:0]  cw_o
);
  for (genvar p = 1; p < CW_N; p++) begin : g_pos
    assign cw_o[p-1] = cw_i[p-1] ^ (en_i && (syn_i == CHK_N'(p)));
  end
  assign cw_o[CW_N-1] = cw_i[CW_N-1];
endmodule

// File: rtl/secded_extract.sv
module secded_extract
  import secded_pkg::*;
#(
  parameter int DATA_N = DATA_W,
  parameter int CW_N   = CW_W
) (
  input  logic [CW_N-1:0]   cw_i,
  output logic [DATA_N-1:0] data_o
);
  for (genvar i = 0; i < DATA_N; i++) begin : g_bit
    localparam int POS = pos_of_data(i);
    assign data_o[i] = cw_i[POS-1];
  end
endmodule

// File: rtl/secded_check.sv
module secded_check
  import secded_pkg::*;
(
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic [1:0]        status_o,
  output logic              meta_fix_o
);
  logic [CHK_W-1:0] syn;
  logic             odd;
  logic             flip_en;
  logic [CW_W-1:0]  cw_fixed;

  secded_syndrome #(.CHK_N(CHK_W), .CW_N(CW_W)) u_syn (
    .cw_i (cw_i),
    .syn_o(syn),
    .odd_o(odd)
  );

  secded_classify #(.CHK_N(CHK_W), .CW_N(CW_W)) u_cls (
    .syn_i    (syn),
    .odd_i    (odd),
    .flip_en_o(flip_en),
    .status_o (status_o),
    .meta_o   (meta_fix_o)
  );

  secded_flip #(.CHK_N(CHK_W), .CW_N(CW_W)) u_flip (
    .cw_i (cw_i),
    .syn_i(syn),
    .en_i (flip_en),
    .cw_o (cw_fixed)
  );

  secded_extract #(.DATA_N(DATA_W), .CW_N(CW_W)) u_ext (
    .cw_i  (cw_fixed),
    .data_o(data_o)
  );
endmodule

// File: rtl/secded_check_sva.sv
module secded_check_sva
  import secded_pkg::*;
(
  input logic [CW_W-1:0]   cw_i,
  input logic [DATA_W-1:0] data_o,
  input logic [1:0]        status_o,
  input logic              meta_fix_o
);
  logic [DATA_W-1:0] raw;
  assign raw = extract(cw_i);

  always_comb begin
    // R7
    no_code11_chk: assert (status_o != 2'b11);
    // R7
    meta_only_fix_chk: assert (!meta_fix_o || status_o == ST_FIX);
    // R1
    clean_pass_chk: assert (status_o != ST_OK || data_o == raw);
    // R5
    dbl_raw_chk: assert (status_o != ST_DBL || data_o == raw);
    // R3
    meta_data_kept_chk: assert (!(status_o == ST_FIX && meta_fix_o) || data_o == raw);
    // R2
    one_bit_fix_chk: assert (!(status_o == ST_FIX && !meta_fix_o) || $countones(data_o ^ raw) == 1);
  end
endmodule

bind secded_check secded_check_sva u_sva (
  .cw_i      (cw_i),
  .data_o    (data_o),
  .status_o  (status_o),
  .meta_fix_o(meta_fix_o)
);

// File: tb/secded_check_tb.sv
module secded_check_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int CWN = 39;

  logic           clk;
  logic [CWN-1:0] cw;
  logic [DW-1:0]  data_o;
  logic [1:0]     status_o;
  logic           meta_fix_o;
  int total = 0;
  int bad = 0;
  bit done = 0;

  secded_check u_dut (
    .cw_i      (cw),
    .data_o    (data_o),
    .status_o  (status_o),
    .meta_fix_o(meta_fix_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench model: 1-based position of payload bit idx
  function automatic int dpos(int idx);
    int n = 0;
    for (int p = 1; p <= 38; p++) begin
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32) begin
        if (n == idx) return p;
        n++;
      end
    end
    return 0;
  endfunction

  function automatic logic [CWN-1:0] mk(logic [DW-1:0] d);
    logic [CWN-1:0] w = '0;
    for (int i = 0; i < DW; i++) w[dpos(i)-1] = d[i];
    for (int k = 0; k < 6; k++) begin
      logic c = 1'b0;
      for (int p = 1; p <= 38; p++) if (p[k]) c ^= w[p-1];
      w[(1 << k) - 1] = c;
    end
    w[38] = ^w[37:0];
    return w;
  endfunction

  function automatic logic [DW-1:0] rd(logic [CWN-1:0] w);
    logic [DW-1:0] d;
    for (int i = 0; i < DW; i++) d[i] = w[dpos(i)-1];
    return d;
  endfunction

  task automatic expect_out(string req, logic [DW-1:0] ed, logic [1:0] es, logic em);
    #1;
    total++;
    if (data_o !== ed || status_o !== es || meta_fix_o !== em) begin
      bad++;
      $display("FAIL %s cw=%h got data=%h st=%b meta=%b exp data=%h st=%b meta=%b",
               req, cw, data_o, status_o, meta_fix_o, ed, es, em);
    end
  endtask

  logic [DW-1:0] pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h8000_0011};

  task automatic t_start;
    cw = '0;
    expect_out("R1 all-zero start", 32'h0, 2'b00, 1'b0);
  endtask

  task automatic t_clean;
    foreach (pats[j]) begin
      cw = mk(pats[j]);
      expect_out("R1 clean", pats[j], 2'b00, 1'b0);
    end
  endtask

  task automatic t_single_data;
    foreach (pats[j]) begin
      for (int i = 0; i < DW; i++) begin
        cw = mk(pats[j]);
        cw[dpos(i)-1] ^= 1'b1;
        expect_out("R2 payload flip", pats[j], 2'b01, 1'b0);
      end
    end
  endtask

  task automatic t_single_check;
    foreach (pats[j]) begin
      for (int k = 0; k < 6; k++) begin
        cw = mk(pats[j]);
        cw[(1 << k) - 1] ^= 1'b1;
        expect_out("R3 check-bit flip", pats[j], 2'b01, 1'b1);
      end
    end
  endtask

  task automatic t_parity_bit;
    foreach (pats[j]) begin
      cw = mk(pats[j]);
      cw[38] ^= 1'b1;
      expect_out("R4 parity-bit flip", pats[j], 2'b01, 1'b1);
    end
  endtask

  task automatic t_double;
    int pa [6] = '{3, 1, 5, 39, 38, 32};
    int pb [6] = '{7, 38, 32, 12, 39, 16};
    foreach (pats[j]) begin
      for (int m = 0; m < 6; m++) begin
        cw = mk(pats[j]);
        cw[pa[m]-1] ^= 1'b1;
        cw[pb[m]-1] ^= 1'b1;
        expect_out("R5 double flip", rd(cw), 2'b10, 1'b0);
      end
    end
  endtask

  task automatic t_over_range;
    // positions 32 ^ 7 = 39 plus parity bit: syndrome 39, odd parity
    foreach (pats[j]) begin
      cw = mk(pats[j]);
      cw[31] ^= 1'b1;
      cw[6]  ^= 1'b1;
      cw[38] ^= 1'b1;
      expect_out("R6 out-of-range syndrome", rd(cw), 2'b10, 1'b0);
      total++;
      if (status_o == 2'b11) begin
        bad++;
        $display("FAIL R7 status=%b expected not 11", status_o);
      end
    end
  endtask

  initial begin
    cw = '0;
    @(negedge clk);
    t_start();
    t_clean();
    t_single_data();
    t_single_check();
    t_parity_bit();
    t_double();
    t_over_range();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired got running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule